// File: doc/BRIEF.md
# Barrel-Scheduled Three-Stage Multithreaded Core

This block is a compact in-order processor core that keeps several independent hardware threads in flight at once. Every clock cycle it fetches one instruction, and the thread it fetches for changes every cycle in a strict round-robin rotation. Each thread owns a program counter and a bank of general registers. All register banks sit in one banked store and are selected by the thread number that travels down the pipe with each instruction. Instructions pass through three stages: fetch and decode, then operand read with execute and memory access, then writeback.

At least two threads are always in the rotation. For this reason a thread's previous result has been written back, and its previous branch resolved, before that thread is fetched again. The core therefore has no forwarding network and no interlock. Multiplication is split into two three-operand instructions, one giving the low word and one giving the high word of the unsigned product, so no per-thread product registers exist. A halt instruction retires a thread. Its slot stays in the rotation as an empty slot, and a completion flag rises once every active thread has halted. Instruction fetch is combinational through a single port that carries the fetching thread's number. The data port is shared, reads combinationally and writes on the clock edge.

Top module: `barrel_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `halted` is all zeros, `done` is low and the fetch port shows thread 0.
- R2: With three active threads the fetch thread follows 0,1,2,0,1,2,... with one step per cycle, and no thread is fetched in two consecutive cycles.
- R3: Thread t's program counter starts at t*STRIDE (word addresses) and advances by one on each of that thread's own fetches, so the first fetches after reset are thread 0 at 0, thread 1 at 16, thread 2 at 32, then thread 0 at 1.
- R4: Instruction format: opcode in [31:28], rd in [27:25], rs1 in [24:22], rs2 in [21:19], and a signed immediate in [18:0]. Opcode 1 ADD, 2 SUB, 3 AND, 4 OR and 5 XOR write rs1 op rs2 to rd. Opcode 6 ADDI writes rs1 plus the immediate to rd. Opcode 0 and the unused codes 13 and 14 do nothing.
- R5: Register 0 of every thread always reads zero, and writes to it are discarded.
- R6: Opcode 7 writes bits [31:0] and opcode 8 writes bits [63:32] of the unsigned 64-bit product rs1*rs2 to rd.
- R7: Opcode 9 loads rd from data word rs1+imm. Opcode 10 stores rs2 to data word rs1+imm, the address being the low DAW bits of the sum.
- R8: Opcode 11 (branch if rs1==rs2) and opcode 12 (branch if rs1!=rs2), when taken, set the issuing thread's PC to the branch's own address plus the immediate. Only that thread's PC changes, and no instruction is discarded.
- R9: Threads are isolated. The same register number in different threads names different storage, and an instruction in a thread sees the result of that thread's previous instruction without any stall.
- R10: Opcode 15 halts the thread: its `halted` bit rises and stays set, its PC freezes at the halt's address, and its slot is still taken in the rotation but performs no work. `done` is high exactly when every active thread is halted.
- R11: `thr_count` selects the number of active threads. Values below 2 act as 2 and values above NTHR act as NTHR. Only threads below that count are fetched or counted for `done`.
- R12: With NREG below 8, register numbers NREG and above read zero and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_count | input | TCW | Number of active threads (clamped to 2..NTHR) |
| imem_addr | output | IAW | Word address being fetched |
| imem_tid | output | TIDW | Thread owning the current fetch |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | DAW | Data word address |
| dmem_we | output | 1 | Store strobe, write at the next clock edge |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data at dmem_addr, same cycle |
| halted | output | NTHR | Per-thread halt status |
| done | output | 1 | All active threads halted |

## Verification
In any cycle one thread's taken branch rewrites its own PC while a different thread is being fetched. In the same cycle, a third thread's result is written into the register store while the thread in execute reads its operands. A counting loop with a backward branch runs alongside two straight-line programs that use the same register numbers. A scoreboard then compares every store, in per-thread order, with values worked out from the instruction definitions, so that a wrong PC or a write into the wrong bank shows up as a mismatched or unexpected store. The rotation order is followed cycle by cycle with three threads, with two threads, and with a thread count of zero that is clamped up to two.

// File: rtl/bc_pkg.sv
// Shared opcode and decoded-instruction types for the barrel core.
// Assumes a fixed 32-bit instruction word with 3-bit register fields.
package bc_pkg;
    localparam int ILEN = 32;
    localparam int RIW  = 3;
    localparam int IMMW = 19;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_ADDI  = 4'd6,
        OP_MULLO = 4'd7,
        OP_MULHI = 4'd8,
        OP_LW    = 4'd9,
        OP_SW    = 4'd10,
        OP_BEQ   = 4'd11,
        OP_BNE   = 4'd12,
        OP_HALT  = 4'd15
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [RIW-1:0]  rd;
        logic [RIW-1:0]  rs1;
        logic [RIW-1:0]  rs2;
        logic [IMMW-1:0] imm;
    } dec_t;
endpackage

// File: rtl/bc_decode.sv
// Splits a raw instruction word into its fields.
// Assumes unknown opcodes are handled as no-ops downstream.
module bc_decode
    import bc_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    // field extraction
    always_comb begin
        dec.op  = op_e'(instr[31:28]);
        dec.rd  = instr[27:25];
        dec.rs1 = instr[24:22];
        dec.rs2 = instr[21:19];
        dec.imm = instr[IMMW-1:0];
    end
endmodule

// File: rtl/bc_regbank.sv
// Banked register store: one bank of NREG words per thread, two read
// ports for the executing thread and one write port for writeback.
// Assumes register 0 and indices at or above NREG read as zero.
module bc_regbank
    import bc_pkg::*;
#(
    parameter int NTHR = 3,
    parameter int NREG = 8,
    parameter int XLEN = 32,
    parameter int TIDW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TIDW-1:0] rd_tid,
    input  logic [RIW-1:0]  ra_idx,
    input  logic [RIW-1:0]  rb_idx,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    input  logic            we,
    input  logic [TIDW-1:0] wr_tid,
    input  logic [RIW-1:0]  wr_idx,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] mem [NTHR][NREG];

    // writeback into the owning thread's bank, dropping r0 and absent registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NTHR; t++)
                for (int r = 0; r < NREG; r++)
                    mem[t][r] <= '0;
        end else if (we && wr_idx != '0 && int'(wr_idx) < NREG && int'(wr_tid) < NTHR) begin
            mem[wr_tid][wr_idx] <= wr_data;
        end
    end

    // operand read for the thread in execute
    always_comb begin
        ra_data = '0;
        rb_data = '0;
        if (ra_idx != '0 && int'(ra_idx) < NREG && int'(rd_tid) < NTHR)
            ra_data = mem[rd_tid][ra_idx];
        if (rb_idx != '0 && int'(rb_idx) < NREG && int'(rd_tid) < NTHR)
            rb_data = mem[rd_tid][rb_idx];
    end
endmodule

// File: rtl/bc_exec.sv
// Combinational execute unit: ALU, split multiply, address and branch.
// Assumes load data returns in the same cycle as the address.
module bc_exec
    import bc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IAW  = 8,
    parameter int DAW  = 8
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [IAW-1:0]  pc,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] result,
    output logic            rf_we,
    output logic            mem_we,
    output logic [DAW-1:0]  mem_addr,
    output logic            br_taken,
    output logic [IAW-1:0]  br_target
);
    logic [XLEN-1:0]   simm;
    logic [2*XLEN-1:0] prod;

    assign simm      = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
    assign prod      = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    assign mem_addr  = DAW'(a + simm);
    assign br_target = pc + IAW'(dec.imm);

    // operation select
    always_comb begin
        result   = '0;
        rf_we    = 1'b1;
        mem_we   = 1'b0;
        br_taken = 1'b0;
        case (dec.op)
            OP_ADD:   result = a + b;
            OP_SUB:   result = a - b;
            OP_AND:   result = a & b;
            OP_OR:    result = a | b;
            OP_XOR:   result = a ^ b;
            OP_ADDI:  result = a + simm;
            OP_MULLO: result = prod[XLEN-1:0];
            OP_MULHI: result = prod[2*XLEN-1:XLEN];
            OP_LW:    result = ld_data;
            OP_SW:    begin rf_we = 1'b0; mem_we = 1'b1; end
            OP_BEQ:   begin rf_we = 1'b0; br_taken = (a == b); end
            OP_BNE:   begin rf_we = 1'b0; br_taken = (a != b); end
            default:  rf_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/barrel_core.sv
// Three-stage fine-grained multithreaded core. Fetch/decode picks the
// next thread each cycle; execute reads that thread's bank, runs the
// ALU and data access and resolves branches; writeback updates the bank.
// Assumes at least two threads rotate, so no hazard logic is needed.
module barrel_core
    import bc_pkg::*;
#(
    parameter int NTHR   = 3,
    parameter int NREG   = 8,
    parameter int XLEN   = 32,
    parameter int IAW    = 8,
    parameter int DAW    = 8,
    parameter int STRIDE = 16,
    localparam int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1,
    localparam int TCW   = $clog2(NTHR + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TCW-1:0]  thr_count,
    output logic [IAW-1:0]  imem_addr,
    output logic [TIDW-1:0] imem_tid,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [DAW-1:0]  dmem_addr,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [NTHR-1:0] halted,
    output logic            done
);
    logic [TCW-1:0]  eff_cnt;
    logic [TIDW-1:0] cur_tid, nxt_tid;
    logic [IAW-1:0]  pc_q [NTHR];
    logic [NTHR-1:0] halted_q;
    logic            ran_q;
    dec_t            f_dec;
    logic            f_live;

    logic            fe_valid;
    dec_t            fe_dec;
    logic [TIDW-1:0] fe_tid;
    logic [IAW-1:0]  fe_pc;

    logic [XLEN-1:0] ex_a, ex_b, ex_res;
    logic            ex_rfwe, ex_mwe, ex_taken;
    logic [IAW-1:0]  ex_target;

    logic            wb_valid;
    logic [TIDW-1:0] wb_tid;
    logic [RIW-1:0]  wb_rd;
    logic [XLEN-1:0] wb_val;

    // clamp the configured thread count to 2..NTHR
    assign eff_cnt = (thr_count < TCW'(2)) ? TCW'(2) :
                     ((thr_count > TCW'(NTHR)) ? TCW'(NTHR) : thr_count);
    // next slot in the rotation
    assign nxt_tid = (TCW'(cur_tid) + TCW'(1) >= eff_cnt) ? '0 : cur_tid + TIDW'(1);

    assign imem_tid  = cur_tid;
    assign imem_addr = pc_q[cur_tid];
    assign f_live    = !halted_q[cur_tid];
    assign halted    = halted_q;

    bc_decode u_dec (.instr(imem_rdata), .dec(f_dec));

    // thread rotation and reset marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tid <= '0;
            ran_q   <= 1'b0;
        end else begin
            cur_tid <= nxt_tid;
            ran_q   <= 1'b1;
        end
    end

    // per-thread PC and halt state; fetch advance, then branch redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTHR; i++) pc_q[i] <= IAW'(i * STRIDE);
            halted_q <= '0;
        end else begin
            if (f_live && f_dec.op == OP_HALT) halted_q[cur_tid] <= 1'b1;
            else if (f_live) pc_q[cur_tid] <= pc_q[cur_tid] + IAW'(1);
            if (fe_valid && ex_taken) pc_q[fe_tid] <= ex_target;
        end
    end

    // fetch/decode to execute register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_valid <= 1'b0;
            fe_dec   <= '0;
            fe_tid   <= '0;
            fe_pc    <= '0;
        end else begin
            fe_valid <= f_live && f_dec.op != OP_HALT;
            fe_dec   <= f_dec;
            fe_tid   <= cur_tid;
            fe_pc    <= pc_q[cur_tid];
        end
    end

    bc_regbank #(.NTHR(NTHR), .NREG(NREG), .XLEN(XLEN), .TIDW(TIDW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_tid(fe_tid), .ra_idx(fe_dec.rs1), .rb_idx(fe_dec.rs2),
        .ra_data(ex_a), .rb_data(ex_b),
        .we(wb_valid), .wr_tid(wb_tid), .wr_idx(wb_rd), .wr_data(wb_val)
    );

    bc_exec #(.XLEN(XLEN), .IAW(IAW), .DAW(DAW)) u_ex (
        .dec(fe_dec), .a(ex_a), .b(ex_b), .pc(fe_pc), .ld_data(dmem_rdata),
        .result(ex_res), .rf_we(ex_rfwe), .mem_we(ex_mwe), .mem_addr(dmem_addr),
        .br_taken(ex_taken), .br_target(ex_target)
    );

    assign dmem_we    = fe_valid && ex_mwe;
    assign dmem_wdata = ex_b;

    // execute to writeback register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_tid   <= '0;
            wb_rd    <= '0;
            wb_val   <= '0;
        end else begin
            wb_valid <= fe_valid && ex_rfwe;
            wb_tid   <= fe_tid;
            wb_rd    <= fe_dec.rd;
            wb_val   <= ex_res;
        end
    end

    // completion: every active thread halted
    always_comb begin
        done = 1'b1;
        for (int i = 0; i < NTHR; i++)
            if (i < int'(eff_cnt) && !halted_q[i]) done = 1'b0;
    end

    AST_TID_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        ran_q |-> cur_tid != $past(cur_tid)) else $error("same thread twice"); // R2
    AST_TID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ran_q |-> TCW'(cur_tid) < eff_cnt) else $error("inactive thread fetched"); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ran_q |-> (($past(halted_q) & ~halted_q) == '0)) else $error("halt cleared"); // R10
    AST_BR_OTHER_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && ex_taken) |-> fe_tid != cur_tid) else $error("branch races own fetch"); // R8
    AST_WB_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && ran_q) |-> wb_tid != fe_tid) else $error("writeback hits executing bank"); // R9
endmodule

// File: tb/sim_barrel_core.sv
`timescale 1ns/1ps
module sim_barrel_core;
    localparam int NTHR = 3;
    localparam int TCW  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [TCW-1:0] thr_count = 2'd3;
    logic [7:0]  imem_addr;
    logic [1:0]  imem_tid;
    logic [31:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;
    logic [2:0]  halted;
    logic        done;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int n_chk = 0;
    int n_fail = 0;
    int rot_err = 0;
    int eff = 3;
    logic [1:0] exp_tid = '0;
    bit mon_en = 1'b0;
    logic [39:0] q0[$];
    logic [39:0] q1[$];
    logic [39:0] q2[$];

    always #2 clk = ~clk;

    barrel_core #(.NTHR(NTHR), .NREG(6), .XLEN(32), .IAW(8), .DAW(8), .STRIDE(16)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_count(thr_count),
        .imem_addr(imem_addr), .imem_tid(imem_tid), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .halted(halted), .done(done)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int rd, input int rs1,
                                        input int rs2, input int imm);
        return {op[3:0], rd[2:0], rs1[2:0], rs2[2:0], imm[18:0]};
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'd5:          return "R5";
            8'd32, 8'd33:  return "R6";
            8'd34:         return "R7";
            8'd35:         return "R12";
            8'd64, 8'd65:  return "R8";
            default:       return "R4";
        endcase
    endfunction

    // driver side of the scoreboard: queue an expected store
    task automatic expect_store(input logic [7:0] a, input logic [31:0] d);
        case (a[7:5])
            3'd0:    q0.push_back({a, d});
            3'd1:    q1.push_back({a, d});
            default: q2.push_back({a, d});
        endcase
    endtask

    task automatic load_programs();
        for (int i = 0; i < 256; i++) begin imem[i] = '0; dmem[i] = '0; end
        // thread 0: register-register and immediate ops (R4, R5, R9)
        imem[0]  = enc(6, 1, 0, 0, 5);
        imem[1]  = enc(6, 2, 0, 0, -3);
        imem[2]  = enc(1, 3, 1, 2, 0);
        imem[3]  = enc(10, 0, 0, 3, 0);
        imem[4]  = enc(2, 3, 1, 2, 0);
        imem[5]  = enc(10, 0, 0, 3, 1);
        imem[6]  = enc(5, 4, 1, 2, 0);
        imem[7]  = enc(10, 0, 0, 4, 2);
        imem[8]  = enc(3, 4, 1, 2, 0);
        imem[9]  = enc(10, 0, 0, 4, 3);
        imem[10] = enc(4, 4, 1, 2, 0);
        imem[11] = enc(10, 0, 0, 4, 4);
        imem[12] = enc(6, 0, 1, 0, 7);
        imem[13] = enc(10, 0, 0, 0, 5);
        imem[14] = enc(15, 0, 0, 0, 0);
        // thread 1: split multiply, load/store, reduced bank (R6, R7, R12)
        imem[16] = enc(6, 1, 0, 0, -1);
        imem[17] = enc(6, 2, 0, 0, -2);
        imem[18] = enc(7, 3, 1, 2, 0);
        imem[19] = enc(8, 4, 1, 2, 0);
        imem[20] = enc(10, 0, 0, 3, 32);
        imem[21] = enc(10, 0, 0, 4, 33);
        imem[22] = enc(9, 5, 0, 0, 33);
        imem[23] = enc(6, 5, 5, 0, 4);
        imem[24] = enc(10, 0, 0, 5, 34);
        imem[25] = enc(6, 6, 0, 0, 9);
        imem[26] = enc(10, 0, 0, 6, 35);
        imem[27] = enc(15, 0, 0, 0, 0);
        // thread 2: counting loop and forward skip (R8)
        imem[32] = enc(6, 1, 0, 0, 4);
        imem[33] = enc(6, 2, 0, 0, 0);
        imem[34] = enc(1, 2, 2, 1, 0);
        imem[35] = enc(6, 1, 1, 0, -1);
        imem[36] = enc(12, 0, 1, 0, -2);
        imem[37] = enc(10, 0, 0, 2, 64);
        imem[38] = enc(11, 0, 0, 0, 2);
        imem[39] = enc(10, 0, 0, 2, 65);
        imem[40] = enc(6, 3, 0, 0, 77);
        imem[41] = enc(10, 0, 0, 3, 65);
        imem[42] = enc(15, 0, 0, 0, 0);
    endtask

    task automatic push_thread(input int t);
        if (t == 0) begin
            expect_store(8'd0, 32'd2);
            expect_store(8'd1, 32'd8);
            expect_store(8'd2, 32'hFFFF_FFF8);
            expect_store(8'd3, 32'd5);
            expect_store(8'd4, 32'hFFFF_FFFD);
            expect_store(8'd5, 32'd0);
        end else if (t == 1) begin
            expect_store(8'd32, 32'd2);
            expect_store(8'd33, 32'hFFFF_FFFD);
            expect_store(8'd34, 32'd1);
            expect_store(8'd35, 32'd0);
        end else begin
            expect_store(8'd64, 32'd10);
            expect_store(8'd65, 32'd77);
        end
    endtask

    // monitor side of the scoreboard: pop and compare each store
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && dmem_we) begin
                logic [39:0] item;
                bit have;
                have = 1'b0;
                item = '0;
                case (dmem_addr[7:5])
                    3'd0: if (q0.size() > 0) begin item = q0.pop_front(); have = 1'b1; end
                    3'd1: if (q1.size() > 0) begin item = q1.pop_front(); have = 1'b1; end
                    default: if (q2.size() > 0) begin item = q2.pop_front(); have = 1'b1; end
                endcase
                if (!have)
                    chk(1'b0, tag_of(dmem_addr), "unexpected store", {24'd0, dmem_addr, dmem_wdata}, 64'd0);
                else
                    chk({dmem_addr, dmem_wdata} == item, tag_of(item[39:32]), "store addr/data",
                        {24'd0, dmem_addr, dmem_wdata}, {24'd0, item});
            end
        end
    end

    // rotation monitor (R2, R11)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mon_en) begin
                if (imem_tid != exp_tid) rot_err++;
                exp_tid = (int'(exp_tid) + 1 >= eff) ? 2'd0 : exp_tid + 2'd1;
            end
        end
    end

    task automatic do_reset(input logic [TCW-1:0] tc);
        @(negedge clk);
        mon_en = 1'b0;
        rst_n = 1'b0;
        thr_count = tc;
        eff = (int'(tc) < 2) ? 2 : int'(tc);
        repeat (3) @(negedge clk);
        chk(halted == 3'b000 && done == 1'b0, "R1", "status during reset", {halted, done}, 64'd0);
        rot_err = 0;
        exp_tid = '0;
        rst_n = 1'b1;
        mon_en = 1'b1;
        #1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (done) break;
            @(negedge clk);
            #1;
        end
        chk(done == 1'b1, "R10", "done rises", done, 1);
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic step_sample();
        @(negedge clk);
        #1;
    endtask

    initial begin
        load_programs();

        // phase with three threads
        push_thread(0); push_thread(1); push_thread(2);
        do_reset(2'd3);
        chk(imem_tid == 2'd0 && imem_addr == 8'd0, "R1", "first fetch", {imem_tid, imem_addr}, 0);
        chk(halted == 3'b000 && done == 1'b0, "R1", "status after release", {halted, done}, 0);
        step_sample();
        chk(imem_tid == 2'd1 && imem_addr == 8'd16, "R3", "thread 1 start", {imem_tid, imem_addr}, {2'd1, 8'd16});
        step_sample();
        chk(imem_tid == 2'd2 && imem_addr == 8'd32, "R3", "thread 2 start", {imem_tid, imem_addr}, {2'd2, 8'd32});
        step_sample();
        chk(imem_tid == 2'd0 && imem_addr == 8'd1, "R3", "thread 0 advance", {imem_tid, imem_addr}, {2'd0, 8'd1});
        wait_done();
        chk(halted == 3'b111, "R10", "all halted", halted, 3'b111);
        chk(q0.size() + q1.size() + q2.size() == 0, "R9", "all stores seen",
            q0.size() + q1.size() + q2.size(), 0);
        chk(rot_err == 0, "R2", "rotation 0,1,2", rot_err, 0);
        while (imem_tid != 2'd0) step_sample();
        chk(imem_addr == 8'd14, "R10", "halted pc frozen", imem_addr, 14);
        step_sample();
        chk(imem_tid == 2'd1, "R10", "halted slot still rotates", imem_tid, 1);

        // phase with two threads
        push_thread(0); push_thread(1);
        do_reset(2'd2);
        chk(imem_tid == 2'd0, "R11", "two-thread slot 0", imem_tid, 0);
        step_sample();
        chk(imem_tid == 2'd1, "R11", "two-thread slot 1", imem_tid, 1);
        step_sample();
        chk(imem_tid == 2'd0 && imem_addr == 8'd1, "R11", "two-thread wrap", {imem_tid, imem_addr}, {2'd0, 8'd1});
        wait_done();
        chk(halted == 3'b011, "R11", "only active threads halt", halted, 3'b011);
        chk(q0.size() + q1.size() + q2.size() == 0, "R9", "two-thread stores seen",
            q0.size() + q1.size() + q2.size(), 0);
        chk(rot_err == 0, "R11", "rotation 0,1", rot_err, 0);

        // phase with a count below the minimum
        push_thread(0); push_thread(1);
        do_reset(2'd0);
        step_sample();
        step_sample();
        step_sample();
        chk(imem_tid == 2'd1, "R11", "clamped count slot", imem_tid, 1);
        wait_done();
        chk(halted == 3'b011, "R11", "clamped count halts", halted, 3'b011);
        chk(rot_err == 0, "R11", "clamped rotation", rot_err, 0);
        chk(q0.size() + q1.size() + q2.size() == 0, "R9", "clamped stores seen",
            q0.size() + q1.size() + q2.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule